// File: doc/BRIEF.md
# Time-Base Divider with Buzzer Tone

This block is a free-running binary divider that measures time in ticks of a selectable time-base source. Three single-cycle clock-enable inputs feed it: a tick from a 32.768 kHz crystal domain, the system clock tick and a tick from another timer's prescaler. A two-bit select field picks one of them. The divider raises two events. The slow event recurs every 16384 ticks, which is half a second on the crystal and suits a real-time clock. The fast event recurs after 32, 128, 512 or 2048 ticks, chosen by software. Each event sets a sticky flag that software clears with a one-cycle clear pulse.

The same chain drives a buzzer pin with a square wave of 50% duty at the source rate divided by 8 or by 16. On a crystal source that is 4 kHz or 2 kHz. A run bit starts the chain. Dropping run returns the chain to zero. The source select is sampled only while run is low, so a source change during counting has no effect on the chain.

Top module: `tick_base_timer`

## Requirements
- R1: After reset both flags and the buzzer pin are 0, and the divider is zero.
- R2: The divider advances by one on each clock in which run is 1 and the latched source enable is 1. The latched source code is 0 for the crystal tick, 1 for the system tick, 2 for the prescaler tick and 3 for no source, in which case the divider holds.
- R3: slow_flag becomes 1 one clock after the tick that completes each block of 16384 ticks counted since run rose.
- R4: fast_flag becomes 1 one clock after the tick that completes each block of 2^(5+2·fast_sel) ticks. fast_sel 0..3 gives 32, 128, 512 or 2048 ticks, and fast_sel is used as it stands on that tick.
- R5: When buzz_en is 1, buzz_out equals bit 2 of the tick count when buzz_sel is 0, giving a period of 8 ticks. It equals bit 3 when buzz_sel is 1, giving a period of 16 ticks. Either way the high and low halves are equal.
- R6: buzz_out is 0 whenever buzz_en is 0.
- R7: A flag stays at 1 until a clear pulse arrives. A clear with no event in the same clock drops the flag on the next clock. An event in the same clock as a clear leaves the flag at 1.
- R8: While run is 0 the divider is held at zero, so after a restart the first fast event needs a full period of ticks.
- R9: src_sel is captured on each clock in which run is 0. Changes to it while run is 1 have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xtal_tick | input | 1 | Crystal time-base enable (source 0) |
| sys_tick | input | 1 | System clock enable (source 1) |
| pre_tick | input | 1 | Prescaler output enable (source 2) |
| src_sel | input | 2 | Source code, captured while run is 0 |
| fast_sel | input | 2 | Fast period select, 2^(5+2·n) ticks |
| buzz_sel | input | 1 | 0: divide by 8, 1: divide by 16 |
| buzz_en | input | 1 | Buzzer enable |
| run | input | 1 | 1 counts, 0 holds the divider at zero |
| slow_clr | input | 1 | Clear pulse for slow_flag |
| fast_clr | input | 1 | Clear pulse for fast_flag |
| slow_flag | output | 1 | Sticky slow overflow flag |
| fast_flag | output | 1 | Sticky fast overflow flag |
| buzz_out | output | 1 | Buzzer square wave |

## Verification
The assertions assume that every input changes only between clock edges. They also assume that the tick enables are synchronous one-clock qualifiers, so there is never a tick without a clock edge. The stimulus drives all inputs on the falling clock edge. It picks tick densities, source codes, period selects and clear pulses at random. It toggles run only rarely, so that long count runs reach the slow event. Directed phases place a clear exactly on an overflow tick and change the source in the middle of a run.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_PRE  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;
endpackage

// File: rtl/tbt_src_mux.sv
module tbt_src_mux
  import tbt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] src_sel,
  input  logic       xtal_tick,
  input  logic       sys_tick,
  input  logic       pre_tick,
  output src_e       src_q,
  output logic       tick
);
  // capture the source only while stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   src_q <= SRC_XTAL;
    else if (!run) src_q <= src_e'(src_sel);
  end

  logic en_sel;
  always_comb begin
    case (src_q)
      SRC_XTAL: en_sel = xtal_tick;
      SRC_SYS:  en_sel = sys_tick;
      SRC_PRE:  en_sel = pre_tick;
      default:  en_sel = 1'b0;
    endcase
  end

  assign tick = run & en_sel;
endmodule

// File: rtl/tbt_divider.sv
module tbt_divider #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assign wrap = tick & (&cnt);
endmodule

// File: rtl/tbt_taps.sv
module tbt_taps #(
  parameter int CNT_W     = 14,
  parameter int FAST_N    = 4,
  parameter int FAST_MIN  = 5,
  parameter int FAST_STEP = 2,
  parameter int BUZZ_BIT  = 2,
  localparam int SEL_W    = $clog2(FAST_N)
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             tick,
  input  logic [SEL_W-1:0] fast_sel,
  input  logic             buzz_sel,
  input  logic             buzz_en,
  output logic             fast_ev,
  output logic             buzz_out
);
  logic [FAST_N-1:0] low_full;

  genvar i;
  generate
    for (i = 0; i < FAST_N; i++) begin : g_tap
      localparam int TW = FAST_MIN + FAST_STEP * i;
      assign low_full[i] = &cnt[TW-1:0];
    end
  endgenerate

  assign fast_ev = tick & low_full[fast_sel];

  logic tone;
  assign tone     = buzz_sel ? cnt[BUZZ_BIT+1] : cnt[BUZZ_BIT];
  assign buzz_out = buzz_en & tone;
endmodule

// File: rtl/tbt_flag.sv
module tbt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  // a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/tick_base_timer.sv
module tick_base_timer
  import tbt_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int FAST_N    = 4,
  parameter int FAST_MIN  = 5,
  parameter int FAST_STEP = 2,
  parameter int BUZZ_BIT  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_tick,
  input  logic       sys_tick,
  input  logic       pre_tick,
  input  logic [1:0] src_sel,
  input  logic [1:0] fast_sel,
  input  logic       buzz_sel,
  input  logic       buzz_en,
  input  logic       run,
  input  logic       slow_clr,
  input  logic       fast_clr,
  output logic       slow_flag,
  output logic       fast_flag,
  output logic       buzz_out
);
  src_e             src_q;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             slow_ev;
  logic             fast_ev;

  tbt_src_mux u_mux (
    .clk(clk), .rst_n(rst_n), .run(run), .src_sel(src_sel),
    .xtal_tick(xtal_tick), .sys_tick(sys_tick), .pre_tick(pre_tick),
    .src_q(src_q), .tick(tick)
  );

  tbt_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .cnt(cnt), .wrap(slow_ev)
  );

  tbt_taps #(
    .CNT_W(CNT_W), .FAST_N(FAST_N), .FAST_MIN(FAST_MIN),
    .FAST_STEP(FAST_STEP), .BUZZ_BIT(BUZZ_BIT)
  ) u_taps (
    .cnt(cnt), .tick(tick), .fast_sel(fast_sel), .buzz_sel(buzz_sel),
    .buzz_en(buzz_en), .fast_ev(fast_ev), .buzz_out(buzz_out)
  );

  tbt_flag u_slow (
    .clk(clk), .rst_n(rst_n), .set(slow_ev), .clr(slow_clr), .flag(slow_flag)
  );

  tbt_flag u_fast (
    .clk(clk), .rst_n(rst_n), .set(fast_ev), .clr(fast_clr), .flag(fast_flag)
  );
endmodule

// File: rtl/tbt_checker.sv
module tbt_checker #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic [1:0]       src_q,
  input logic [CNT_W-1:0] cnt,
  input logic             buzz_en,
  input logic             buzz_out,
  input logic             slow_flag,
  input logic             fast_flag,
  input logic             slow_clr,
  input logic             fast_clr
);
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (cnt == $past(cnt)));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> (cnt == $past(cnt) + 1'b1));

  assert_buzz_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !buzz_en |-> !buzz_out);

  assert_slow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_flag && !slow_clr) |=> slow_flag);

  assert_fast_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_flag && !fast_clr) |=> fast_flag);

  assert_stop_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  assert_src_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(src_q));
endmodule

bind tick_base_timer tbt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .src_q(src_q),
  .cnt(cnt), .buzz_en(buzz_en), .buzz_out(buzz_out),
  .slow_flag(slow_flag), .fast_flag(fast_flag),
  .slow_clr(slow_clr), .fast_clr(fast_clr)
);

// File: tb/sim_tick_base_timer.sv
`timescale 1ns/1ps
module sim_tick_base_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xtal_tick = 0, sys_tick = 0, pre_tick = 0;
  logic [1:0] src_sel = 0, fast_sel = 0;
  logic buzz_sel = 0, buzz_en = 0, run = 0, slow_clr = 0, fast_clr = 0;
  logic slow_flag, fast_flag, buzz_out;

  always #4 clk = ~clk;

  tick_base_timer u0 (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .sys_tick(sys_tick),
    .pre_tick(pre_tick), .src_sel(src_sel), .fast_sel(fast_sel),
    .buzz_sel(buzz_sel), .buzz_en(buzz_en), .run(run),
    .slow_clr(slow_clr), .fast_clr(fast_clr),
    .slow_flag(slow_flag), .fast_flag(fast_flag), .buzz_out(buzz_out)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit cmp_on = 0;

  // reference state built from the requirements
  logic [1:0]  m_src;
  int unsigned m_cnt;
  logic        m_slow, m_fast;

  function automatic logic sel_en(logic [1:0] s, logic x, logic y, logic p);
    case (s)
      2'd0: return x;
      2'd1: return y;
      2'd2: return p;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int unsigned fast_len(logic [1:0] f);
    return 32'd1 << (5 + 2 * f);
  endfunction

  function automatic logic exp_buzz(int unsigned c, logic en, logic sel);
    int unsigned half = sel ? 8 : 4;
    return en && ((c % (2 * half)) >= half);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = 0; m_cnt = 0; m_slow = 0; m_fast = 0;
    end else begin
      logic t, es, ef;
      t  = run && sel_en(m_src, xtal_tick, sys_tick, pre_tick);
      es = t && ((m_cnt + 1) % 16384 == 0);
      ef = t && ((m_cnt + 1) % fast_len(fast_sel) == 0);
      m_slow = es ? 1'b1 : (slow_clr ? 1'b0 : m_slow);
      m_fast = ef ? 1'b1 : (fast_clr ? 1'b0 : m_fast);
      if (!run) begin
        m_cnt = 0;
        m_src = src_sel;
      end else if (t) m_cnt = (m_cnt + 1) % 16384;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && rst_n) begin
    check("R3 slow_flag", slow_flag, m_slow);
    check("R4 fast_flag", fast_flag, m_fast);
    check("R5 buzz_out", buzz_out, exp_buzz(m_cnt, buzz_en, buzz_sel));
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    cyc(3);
    check("R1 slow_flag reset", slow_flag, 1'b0);
    check("R1 fast_flag reset", fast_flag, 1'b0);
    check("R1 buzz_out reset", buzz_out, 1'b0);
    rst_n = 1;
    cyc(1);
    cmp_on = 1;

    // R3/R4/R5: system tick every cycle, full slow period
    src_sel = 2'd1; sys_tick = 1; fast_sel = 0; buzz_en = 1; buzz_sel = 0;
    cyc(1);
    run = 1;
    cyc(31);
    check("R4 fast not yet at 31 ticks", fast_flag, 1'b0);
    cyc(1);
    check("R4 fast set after 32 ticks", fast_flag, 1'b1);
    // R9: source changes during run are ignored
    src_sel = 2'd3;
    cyc(16384 - 32 - 1);
    check("R3 slow not yet at 16383 ticks", slow_flag, 1'b0);
    cyc(1);
    check("R3 slow set after 16384 ticks", slow_flag, 1'b1);
    check("R9 counting continued despite src change", slow_flag, 1'b1);

    // R7: plain clear drops the flag
    slow_clr = 1; cyc(1); slow_clr = 0;
    check("R7 slow cleared", slow_flag, 1'b0);
    // R7: clear on the overflow tick, flag stays set
    while (m_cnt % 32 != 31) cyc(1);
    fast_clr = 1; cyc(1); fast_clr = 0;
    check("R7 set wins over clear", fast_flag, 1'b1);

    // R6: buzzer quiet
    buzz_en = 0;
    for (int k = 0; k < 40; k++) begin
      cyc(1);
      check("R6 buzz low when disabled", buzz_out, 1'b0);
    end
    buzz_en = 1; buzz_sel = 1;
    cyc(64);

    // R8: stop clears the chain; restart takes a full fast period
    run = 0; fast_clr = 1; cyc(1); fast_clr = 0;
    src_sel = 2'd1; fast_sel = 2'd1;
    cyc(2);
    run = 1;
    cyc(127);
    check("R8 no fast before 128 ticks after restart", fast_flag, 1'b0);
    cyc(1);
    check("R8 fast after 128 ticks after restart", fast_flag, 1'b1);

    // R2: source 3 holds the divider
    run = 0; src_sel = 2'd3; cyc(1); run = 1; fast_clr = 1; fast_sel = 0;
    cyc(1); fast_clr = 0;
    cyc(100);
    check("R2 no ticks from source 3", fast_flag, 1'b0);
    check("R2 buzz stays at count zero", buzz_out, 1'b0);

    // random phase
    for (int k = 0; k < 60000; k++) begin
      xtal_tick = ($urandom % 4) == 0;
      sys_tick  = ($urandom % 2) == 0;
      pre_tick  = ($urandom % 3) == 0;
      if ($urandom % 2000 == 0) run = ~run;
      if ($urandom % 50 == 0) src_sel = $urandom;
      if ($urandom % 300 == 0) fast_sel = $urandom;
      if ($urandom % 500 == 0) buzz_sel = $urandom;
      if ($urandom % 700 == 0) buzz_en = $urandom;
      slow_clr = ($urandom % 97) == 0;
      fast_clr = ($urandom % 13) == 0;
      cyc(1);
    end
    finish_up();
  end
endmodule